// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card-side clock for an SD host from its base clock. An 8-bit frequency-select word picks the divisor. In a clock control register this word sits in bits [15:8], with a reset value of 0. A zero word passes the base clock straight through. A set bit at position k divides by 2^(k+1). When several bits are set, only the highest one counts. Software picks the smallest divisor that keeps the card clock at or below its target. For example, with a 33 MHz base clock, a word of 01h gives 16.5 MHz, and 40h gives about 258 kHz. This block only applies whatever word it receives.

Every divided output has an equal high and low phase, and each period starts with the high phase. A new select word never cuts a period short: it is adopted only when the current period finishes. Dropping the enable lets the current high phase finish and then holds the clock low. Raising the enable again starts with a full high phase. A stability flag drops as soon as the requested divisor differs from the one in use. It comes back after the first complete period at the new divisor. In pass-through mode the base clock is gated by a latch-based cell, so the output only ever shows whole base-clock pulses.

The asynchronous reset is released through a two-stage synchronizer. The block therefore starts acting on the third rising base-clock edge after reset is released.

Top module: `sdclk_gen`

## Requirements
- R1: During reset, and until the enable is first seen high after the reset release (which takes effect on the third rising edge), `sd_clk` and `clk_stable` are both 0.
- R2: With select 00h and the block running, `sd_clk` follows `clk_base`: high in every high phase of the base clock and low in every low phase.
- R3: A select with only bit k set (01h, 02h, 04h, 08h, 10h, 20h, 40h, 80h) gives a period of 2^(k+1) base cycles, so the divisors run 2, 4, 8, up to 256.
- R4: When more than one select bit is set, the divisor is decided by the most significant set bit alone; for example, 41h behaves exactly like 40h.
- R5: Output frequency equals base frequency divided by the divisor: over a window of N·D base cycles at divisor D, exactly N rising edges appear (01h gives half the base rate, 40h gives 1/128 of it).
- R6: A divided output is high for the first D/2 base cycles of each period and low for the remaining D/2.
- R7: A change of select is adopted only at the end of a full period (after its low phase), or at the next edge in pass-through mode; the running period keeps its length.
- R8: With enable low, the output finishes any high phase under way and then stays low.
- R9: When enable rises while stopped, a divided output goes high at the next rising edge for a full D/2 cycles. Pass-through resumes with a whole base pulse one cycle later.
- R10: `clk_stable` is 0 in the cycle after the requested divisor differs from the active one. It becomes 1 at the end of the first full period run at the requested divisor, and it is 0 while the clock is stopped.
- R11: Entering or leaving pass-through mode, or enabling and disabling it, yields only whole base-clock pulses, never a partial one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 8 | Frequency-select word (0 = pass-through, bit k = divide by 2^(k+1)) |
| clk_en | input | 1 | Card clock enable |
| sd_clk | output | 1 | Divided card clock |
| clk_stable | output | 1 | Card clock running at the requested divisor |

## Verification
The bench drives select changes in the middle of a period. A design that switched at once would leave a shortened high or low phase, which the per-cycle comparison exposes at the exact cycle. It drops the enable partway through a high phase. A design that cut the output would give a runt pulse, and one that ignored the enable would keep toggling. It applies the word 41h to catch a decoder that lets the lowest bit win, and it measures edge counts and high time over whole periods to catch an off-by-one in the counter. It also moves into and out of pass-through mode and toggles the enable there, where a gate controlled straight from the flops would produce sliver pulses or lose a pulse.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Width of the code that names the active divisor: 0 = pass-through,
  // k = divide by 2^k.
  function automatic int unsigned code_width(input int unsigned sel_w);
    return $clog2(sel_w + 1);
  endfunction
endpackage

// File: rtl/sdclk_rst_sync.sv
module sdclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/sdclk_sel_decode.sv
module sdclk_sel_decode #(
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned CODE_W = 4
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [CODE_W-1:0] code
);
  // Priority encoder: the highest set bit wins, so scanning upward overwrites.
  always_comb begin
    code = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel[i]) code = CODE_W'(i + 1);
    end
  end

  // R4: the chosen bit is set and nothing above it is set.
  always_comb begin
    if (code != '0) begin
      assert_msb_wins_R4: assert (sel[code - CODE_W'(1)] && ((sel >> code) == '0));
    end
  end
endmodule

// File: rtl/sdclk_clk_gate.sv
module sdclk_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_latched;

  // Transparent while the clock is low, so the enable is frozen for the whole
  // high phase and only whole pulses pass.
  always_latch begin
    if (!clk) en_latched = en;
  end

  assign gclk = clk & en_latched;
endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code_req,
  output logic              div_o,
  output logic              gate_en_o,
  output logic              stable_o
);
  logic              run_q,    run_n;
  logic [CODE_W-1:0] code_q,   code_n;
  logic [CNT_W-1:0]  cnt_q,    cnt_n;
  logic              div_q,    div_n;
  logic              stable_q, stable_n;

  logic [CNT_W:0]    weight;
  logic [CNT_W-1:0]  half_m1;
  logic              bypass;
  logic              last;
  logic              period_end;
  logic              pending;

  always_comb begin
    weight  = (CNT_W+1)'(1) << (code_q - CODE_W'(1));
    half_m1 = weight[CNT_W-1:0] - CNT_W'(1);
  end

  assign bypass     = (code_q == '0);
  assign last       = (cnt_q == half_m1);
  assign period_end = run_q && en && (bypass || (!div_q && last));
  assign pending    = (code_req != code_q);

  // Next-state logic
  always_comb begin
    run_n  = run_q;
    code_n = code_q;
    cnt_n  = cnt_q;
    div_n  = div_q;
    if (!run_q) begin
      if (en) begin
        run_n  = 1'b1;
        code_n = code_req;
        cnt_n  = '0;
        div_n  = (code_req != '0);
      end
    end else if (bypass) begin
      if (!en) begin
        run_n = 1'b0;
      end else begin
        code_n = code_req;
        cnt_n  = '0;
        div_n  = (code_req != '0);
      end
    end else if (!en && !div_q) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (last) begin
      cnt_n = '0;
      if (div_q) begin
        div_n = 1'b0;
      end else begin
        code_n = code_req;
        div_n  = (code_req != '0);
      end
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end

    if (!run_n)          stable_n = 1'b0;
    else if (pending)    stable_n = 1'b0;
    else if (period_end) stable_n = 1'b1;
    else                 stable_n = stable_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      code_q   <= '0;
      cnt_q    <= '0;
      div_q    <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      run_q    <= run_n;
      code_q   <= code_n;
      cnt_q    <= cnt_n;
      div_q    <= div_n;
      stable_q <= stable_n;
    end
  end

  assign div_o     = div_q;
  assign gate_en_o = run_q && bypass;
  assign stable_o  = stable_q;

  assert_switch_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (code_q != $past(code_q))) |-> ($past(en) && !$past(div_q)));

  assert_stop_from_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (!$past(div_q) && !$past(en)));

  assert_restart_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) && (code_q != '0)) |-> div_q);

  assert_stable_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (code_req != code_q)) |=> !stable_q);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk_base,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             clk_en,
  output logic             sd_clk,
  output logic             clk_stable
);
  localparam int unsigned CODE_W = sdclk_pkg::code_width(SEL_W);
  localparam int unsigned CNT_W  = SEL_W - 1;

  logic              rst_int_n;
  logic [CODE_W-1:0] code_req;
  logic              div_clk;
  logic              gate_en;
  logic              gated_base;

  sdclk_rst_sync i_rst_sync (
    .clk     (clk_base),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  sdclk_sel_decode #(.SEL_W(SEL_W), .CODE_W(CODE_W)) i_decode (
    .sel  (freq_sel),
    .code (code_req)
  );

  sdclk_div_core #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_core (
    .clk       (clk_base),
    .rst_n     (rst_int_n),
    .en        (clk_en),
    .code_req  (code_req),
    .div_o     (div_clk),
    .gate_en_o (gate_en),
    .stable_o  (clk_stable)
  );

  sdclk_clk_gate i_gate (
    .clk  (clk_base),
    .en   (gate_en),
    .gclk (gated_base)
  );

  // The divided flop is always 0 in pass-through mode, so an OR suffices.
  assign sd_clk = gated_base | div_clk;

  assert_reset_quiet_R1: assert property (@(posedge clk_base) disable iff (!rst_n)
    (!rst_int_n) |-> (!clk_stable && !div_clk));
endmodule

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;

  logic       clk_base = 1'b0;
  logic       rst_n    = 1'b0;
  logic [7:0] freq_sel = 8'h00;
  logic       clk_en   = 1'b0;
  logic       sd_clk;
  logic       clk_stable;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  // Reference model state (behavioural)
  int rs       = 0;
  bit m_run    = 1'b0;
  int m_div    = 1;
  int m_pos    = 0;
  bit m_stable = 1'b0;
  bit m_gate   = 1'b0;
  bit m_dhi    = 1'b0;

  sdclk_gen i_sdclk_gen (
    .clk_base   (clk_base),
    .rst_n      (rst_n),
    .freq_sel   (freq_sel),
    .clk_en     (clk_en),
    .sd_clk     (sd_clk),
    .clk_stable (clk_stable)
  );

  always #(CLK_PERIOD/2) clk_base = ~clk_base;

  function automatic int want_div(input logic [7:0] s);
    int d = 1;
    for (int i = 0; i < 8; i++) if (s[i]) d = 2 << i;
    return d;
  endfunction

  always @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      rs = 0; m_run = 0; m_div = 1; m_pos = 0; m_stable = 0; m_gate = 0;
    end else begin
      int  req;
      bit  pend;
      bit  pe;
      req    = want_div(freq_sel);
      m_gate = m_run && (m_div == 1);
      if (rs < 2) begin
        rs++;
      end else begin
        pend = (req != m_div);
        pe   = m_run && clk_en && ((m_div == 1) || (m_pos == m_div - 1));
        if (!m_run) begin
          if (clk_en) begin m_run = 1; m_div = req; m_pos = 0; end
        end else if (m_div == 1) begin
          if (!clk_en) m_run = 0;
          else begin m_div = req; m_pos = 0; end
        end else if (!clk_en && (m_pos >= m_div / 2)) begin
          m_run = 0; m_pos = 0;
        end else if (m_pos == m_div - 1) begin
          m_div = req; m_pos = 0;
        end else begin
          m_pos++;
        end
        if (!m_run)    m_stable = 0;
        else if (pend) m_stable = 0;
        else if (pe)   m_stable = 1;
      end
    end
    m_dhi = m_run && (m_div > 1) && (m_pos < m_div / 2);
  end

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison in both phases of the base clock
  always @(posedge clk_base) begin
    #(QTR);
    if (!done) check(cur_tag, "sd_clk(high phase)", sd_clk, m_gate | m_dhi);
  end

  always @(negedge clk_base) begin
    #(QTR);
    if (!done) begin
      check(cur_tag, "sd_clk(low phase)", sd_clk, m_dhi);
      check(cur_tag, "clk_stable", clk_stable, m_stable);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_base);
  endtask

  task automatic wait_stable(input string tag);
    int k = 0;
    @(negedge clk_base); #(QTR);
    while (!clk_stable && k < 2000) begin
      @(negedge clk_base); #(QTR); k++;
    end
    check(tag, "stable reached", clk_stable, 1'b1);
  endtask

  // Sample the low phase of N*D cycles; count rising edges and high samples.
  task automatic measure(input string tag, input int d, input int n);
    int  rises = 0;
    int  highs = 0;
    logic prev;
    #(QTR); prev = sd_clk;
    for (int i = 0; i < n * d; i++) begin
      @(negedge clk_base); #(QTR);
      if (sd_clk && !prev) rises++;
      if (sd_clk) highs++;
      prev = sd_clk;
    end
    check_int({tag, "/R5"}, "rising edges", rises, n);
    check_int({tag, "/R6"}, "high cycles", highs, n * d / 2);
  endtask

  initial begin
    // R1: reset and the synchronizer window
    cur_tag = "R1";
    cycles(4);
    #(QTR);
    check("R1", "sd_clk in reset", sd_clk, 1'b0);
    check("R1", "clk_stable in reset", clk_stable, 1'b0);
    @(negedge clk_base); rst_n = 1'b1;
    cycles(4);
    #(QTR);
    check("R1", "sd_clk idle after reset", sd_clk, 1'b0);

    // R2/R11: pass-through
    @(negedge clk_base); cur_tag = "R2/R11"; clk_en = 1'b1; freq_sel = 8'h00;
    cycles(20);

    // R3/R7/R10: divide by 2, then measure R5/R6
    cur_tag = "R3/R7/R10/R11"; freq_sel = 8'h01;
    wait_stable("R10");
    cur_tag = "R3/R5/R6";
    measure("R3", 2, 32);

    // R10: change request drops the flag next cycle
    @(negedge clk_base); cur_tag = "R3/R7/R10"; freq_sel = 8'h04;
    @(negedge clk_base); #(QTR);
    check("R10", "stable drops after change", clk_stable, 1'b0);
    wait_stable("R10");
    cycles(16);

    // R4: two bits set, top one decides (41h -> /128)
    @(negedge clk_base); cur_tag = "R4/R7"; freq_sel = 8'h41;
    wait_stable("R4");
    cur_tag = "R4/R5/R6";
    measure("R4", 128, 2);

    // R7: mid-period change 08h -> 02h
    @(negedge clk_base); cur_tag = "R7"; freq_sel = 8'h08;
    wait_stable("R7");
    cycles(3);
    freq_sel = 8'h02;
    cycles(40);

    // R8/R9: drop enable during a high phase, then restart
    freq_sel = 8'h08;
    wait_stable("R8");
    @(negedge clk_base); #(QTR);
    while (!sd_clk) begin @(negedge clk_base); #(QTR); end
    cur_tag = "R8"; clk_en = 1'b0;
    cycles(20);
    #(QTR);
    check("R8", "held low while disabled", sd_clk, 1'b0);
    check("R8/R10", "flag low while stopped", clk_stable, 1'b0);
    @(negedge clk_base); cur_tag = "R9"; clk_en = 1'b1;
    @(negedge clk_base); #(QTR);
    check("R9", "restart with high phase", sd_clk, 1'b1);
    cycles(30);

    // R11: into pass-through, toggle enable there, then out again
    @(negedge clk_base); cur_tag = "R11/R2"; freq_sel = 8'h00;
    cycles(20);
    cur_tag = "R11/R8"; clk_en = 1'b0;
    cycles(5);
    cur_tag = "R11/R9"; clk_en = 1'b1;
    cycles(10);
    cur_tag = "R11/R7"; freq_sel = 8'h10;
    cycles(70);

    // R3: largest divisor
    cur_tag = "R3"; freq_sel = 8'h80;
    wait_stable("R3");
    cur_tag = "R3/R5/R6";
    measure("R3", 256, 1);

    // R1: reset in the middle of operation
    @(negedge clk_base); cur_tag = "R1"; rst_n = 1'b0;
    cycles(3);
    #(QTR);
    check("R1", "sd_clk after mid reset", sd_clk, 1'b0);
    @(negedge clk_base); rst_n = 1'b1; freq_sel = 8'h01;
    cur_tag = "R1/R3";
    cycles(20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog run did not finish got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule